// File: doc/BRIEF.md
# Flyby DMA Channel Sequencer

This block runs one DMA channel that moves data between a peripheral and memory in a single bus cycle per item. The channel drives only the memory address and the bus control strobes. The peripheral puts data on the shared data bus, or takes data from it, when it sees the acknowledge output. One configuration bit decides whether memory is read, with the peripheral receiving the data, or memory is written, with the peripheral supplying the data.

Software loads a start address, a byte count, an operand size and three mode bits, then pulses `start`. From then on the active-low request line paces the transfers. Each recognised request produces either one transfer (cycle steal) or a run of back-to-back transfers that lasts while the request stays asserted (burst). Before every bus cycle the channel waits for a grant. A request can be qualified on one sample or on two consecutive samples. A transfer whose address falls into a protected internal-memory window is refused: no bus cycle is run and an error flag is raised. When the byte count runs out, the channel pulses `done` with the final acknowledge and returns to idle.

Top module: `flyby_dma_seq`

## Requirements
- R1: After reset `busy`, `ack`, `addr_strobe`, `done` and `err` are all 0.
- R2: The `cfg_src` value captured at `start` selects the direction. With 1 each transfer reads memory and `bus_rd` is 1 while `addr_strobe` is high. With 0 each transfer writes memory and `bus_rd` is 0 while `addr_strobe` is high.
- R3: Every transfer is a three-cycle bus cycle. `addr_strobe` is high in its last two cycles, and `ack` is high in exactly the same cycles as `addr_strobe`, so `ack` can serve as the peripheral's strobe.
- R4: With `cfg_dbl` = 0 a request sampled low at one rising edge n is enough. The address strobe of the resulting transfer is high from edge n+2.
- R5: With `cfg_dbl` = 1 a request counts only after it has been sampled low at two consecutive edges n and n+1. The address strobe is then high from edge n+3. A request that is low for a single sample starts nothing.
- R6: With `cfg_burst` = 0 (cycle steal) each recognised request yields exactly one transfer. The next transfer needs the request to be seen high at least once before it is asserted again.
- R7: With `cfg_burst` = 1 transfers follow each other with rising address strobes three cycles apart while the request stays low and grant is 1. A transfer during whose first strobe cycle the request is raised is the last one of the burst, and the channel stays armed.
- R8: `bus_addr` equals the current pointer while `addr_strobe` is high. The pointer starts at `ptr_in` and advances after each transfer by the operand size, where `cfg_size` 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes.
- R9: Each transfer takes the operand size off the count. The transfer that starts with a count at or below the size is the last. `done` is high for one cycle together with that transfer's final `ack`, after which `busy` is 0 and requests are ignored until the next `start`. A `start` with a zero count leaves the channel idle.
- R10: While `bus_grant` is 0 no bus cycle starts, and `ack` and `addr_strobe` stay 0. A bus cycle starts at the first edge at which the grant is sampled 1, and its strobe follows one edge later.
- R11: A transfer whose address satisfies (address & WIN_MASK) == WIN_BASE is refused. No strobe is driven, `err` goes to 1 and `busy` goes to 0. This applies both at a new request and at a burst continuation. `err` is cleared by the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads configuration, pointer and count; arms the channel |
| cfg_src | input | 1 | 1: memory read (peripheral receives), 0: memory write |
| cfg_dbl | input | 1 | 1: two-sample request qualification |
| cfg_burst | input | 1 | 1: burst, 0: cycle steal |
| cfg_size | input | 2 | Operand size code: 0 byte, 1 word, 2/3 long |
| ptr_in | input | AW | Start memory address |
| cnt_in | input | CW | Byte count |
| req_n | input | 1 | Peripheral request, active low |
| bus_grant | input | 1 | Bus granted to this channel |
| bus_addr | output | AW | Memory address during a bus cycle, else 0 |
| bus_rd | output | 1 | 1 read, 0 write during a bus cycle |
| addr_strobe | output | 1 | Address valid strobe |
| ack | output | 1 | Peripheral acknowledge / data strobe |
| done | output | 1 | One-cycle pulse with the final acknowledge |
| err | output | 1 | Refused window access |
| busy | output | 1 | Channel armed or transferring |

## Verification
The main sweep runs a complete transfer for every combination of operand size (all four codes), direction, qualification mode and request mode. In each run the bench predicts the address of every strobe, the transfer count and the position of `done` from arithmetic alone, so a wrong increment, a wrong direction or an off-by-one count stands out. Requests held low, released after one sample, or dropped part-way through a burst tell cycle steal apart from burst and one-sample qualification apart from two-sample qualification, and exact latency counts make the same distinction. A withheld grant, a start address inside the window and a burst that runs into the window exercise the refusal and waiting paths.

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter logic [AW-1:0] WIN_BASE = 16'hF000,
  parameter logic [AW-1:0] WIN_MASK = 16'hF000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_src,
  input  logic          cfg_dbl,
  input  logic          cfg_burst,
  input  logic [1:0]    cfg_size,
  input  logic [AW-1:0] ptr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          req_n,
  input  logic          bus_grant,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          addr_strobe,
  output logic          ack,
  output logic          done,
  output logic          err,
  output logic          busy
);

  typedef enum logic [2:0] {IDLE, ARMED, REL, WAITG, C0, C2, C4} st_t;

  st_t st;
  logic [AW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic src_r, dbl_r, bur_r;
  logic [1:0] size_r;
  logic q1, q2, err_r;

  function automatic logic in_win(input logic [AW-1:0] a);
    return (a & WIN_MASK) == WIN_BASE;
  endfunction

  wire seen = q1 & (q2 | ~dbl_r);
  wire [CW-1:0] step = CW'(1) << (size_r[1] ? 2 : {1'b0, size_r[0]});
  wire last = cnt <= step;
  wire [AW-1:0] ptr_nx = ptr + AW'(step);
  wire cyc = (st == C0) || (st == C2) || (st == C4);

  assign addr_strobe = (st == C2) || (st == C4);
  assign ack         = addr_strobe;
  assign done        = (st == C4) && last;
  assign bus_addr    = cyc ? ptr : '0;
  assign bus_rd      = cyc ? src_r : 1'b1;
  assign busy        = st != IDLE;
  assign err         = err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      ptr <= '0;
      cnt <= '0;
      src_r <= 1'b0;
      dbl_r <= 1'b0;
      bur_r <= 1'b0;
      size_r <= 2'd0;
      q1 <= 1'b0;
      q2 <= 1'b0;
      err_r <= 1'b0;
    end else begin
      q1 <= ~req_n;
      q2 <= q1;
      if (start) begin
        ptr <= ptr_in;
        cnt <= cnt_in;
        src_r <= cfg_src;
        dbl_r <= cfg_dbl;
        bur_r <= cfg_burst;
        size_r <= cfg_size;
        err_r <= 1'b0;
        st <= (cnt_in != '0) ? ARMED : IDLE;
      end else begin
        case (st)
          ARMED:
            if (seen) begin
              if (in_win(ptr)) begin
                err_r <= 1'b1;
                st <= IDLE;
              end else begin
                st <= bus_grant ? C0 : WAITG;
              end
            end
          WAITG: if (bus_grant) st <= C0;
          C0: st <= C2;
          C2: st <= C4;
          C4: begin
            ptr <= ptr_nx;
            cnt <= last ? '0 : cnt - step;
            if (last) st <= IDLE;
            else if (bur_r && seen) begin
              if (in_win(ptr_nx)) begin
                err_r <= 1'b1;
                st <= IDLE;
              end else begin
                st <= bus_grant ? C0 : WAITG;
              end
            end else st <= bur_r ? ARMED : REL;
          end
          REL: if (!q1) st <= ARMED;
          default: st <= st;
        endcase
      end
    end
  end

  // R10: every strobe follows a sampled grant
  a_r10_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_strobe) |-> $past(bus_grant, 2));

  // R8: address held across the strobe of one cycle
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe && $past(addr_strobe) |-> $stable(bus_addr));

  // R9: done ends the channel activity
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !busy);

  // R11: refused accesses never reach the bus
  a_r11_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> !in_win(bus_addr));

  // R11: an error leaves the bus quiet
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !addr_strobe && !busy);

endmodule

// File: tb/sim_flyby_dma_seq.sv
module sim_flyby_dma_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cfg_src = 1'b0, cfg_dbl = 1'b0, cfg_burst = 1'b0;
  logic [1:0] cfg_size = 2'd0;
  logic [15:0] ptr_in = '0, cnt_in = '0;
  logic req_n = 1'b1, bus_grant = 1'b1;
  logic [15:0] bus_addr;
  logic bus_rd, addr_strobe, ack, done, err, busy;

  int total = 0, fails = 0, cyc = 0;

  flyby_dma_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src),
    .cfg_dbl(cfg_dbl), .cfg_burst(cfg_burst), .cfg_size(cfg_size), .ptr_in(ptr_in),
    .cnt_in(cnt_in), .req_n(req_n), .bus_grant(bus_grant), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .addr_strobe(addr_strobe), .ack(ack), .done(done), .err(err),
    .busy(busy));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; fails++;
      $display("FAIL watchdog: act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic do_start(input int sz, input bit src, input bit dbl, input bit bur,
                          input logic [15:0] base, input logic [15:0] nb);
    @(negedge clk);
    cfg_size = 2'(sz); cfg_src = src; cfg_dbl = dbl; cfg_burst = bur;
    ptr_in = base; cnt_in = nb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic watch(input int n, output int rises);
    logic prev = 1'b0;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (addr_strobe && !prev) rises++;
      prev = addr_strobe;
    end
  endtask

  task automatic run_xfer(input int sz, input bit src, input bit dbl, input bit bur,
                          input logic [15:0] base, input int nb);
    int step, exp_n, rises, hi, dones, last_rise, t, rel;
    logic prev;
    logic [15:0] ev;
    bit b_ack, b_addr, b_rw, b_sp, b_done;
    step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    exp_n = (nb + step - 1) / step;
    rises = 0; hi = 0; dones = 0; last_rise = -10; t = 0; rel = 0; prev = 1'b0;
    b_ack = 0; b_addr = 0; b_rw = 0; b_sp = 0; b_done = 0;
    do_start(sz, src, dbl, bur, base, 16'(nb));
    req_n = 1'b0;
    while (t < 400) begin
      @(negedge clk);
      t++;
      if (ack !== addr_strobe) b_ack = 1;
      if (addr_strobe) hi++;
      if (addr_strobe && !prev) begin
        ev = base + 16'(rises * step);
        if (bus_addr !== ev) b_addr = 1;
        if (bus_rd !== src) b_rw = 1;
        if (bur && rises > 0 && (t - last_rise) != 3) b_sp = 1;
        last_rise = t;
        rises++;
        if (!bur) begin req_n = 1'b1; rel = 2; end
      end else if (rel > 0) begin
        rel--;
        if (rel == 0) req_n = 1'b0;
      end
      if (done) begin
        dones++;
        if (!ack || rises != exp_n) b_done = 1;
      end
      prev = addr_strobe;
      if (!busy) break;
    end
    req_n = 1'b1;
    chk(!b_addr, "R8 address sequence", int'(b_addr), 0);
    chk(!b_rw, "R2 direction", int'(b_rw), 0);
    chk(!b_ack, "R3 ack equals strobe", int'(b_ack), 0);
    chk(hi == 2 * exp_n, "R3 strobe cycles", hi, 2 * exp_n);
    chk(rises == exp_n, "R9 transfer count", rises, exp_n);
    chk(dones == 1 && !b_done, "R9 done pulse", dones, 1);
    if (bur) chk(!b_sp, "R7 burst spacing", int'(b_sp), 0);
    else chk(rises == exp_n, "R6 one per request", rises, exp_n);
  endtask

  int r, n;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !ack && !addr_strobe && !done && !err, "R1 reset state",
        int'({busy, ack, addr_strobe, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ack && !addr_strobe && !done && !err, "R1 after release",
        int'({busy, ack, addr_strobe, done, err}), 0);

    for (int sz = 0; sz < 4; sz++)
      for (int src = 0; src < 2; src++)
        for (int dbl = 0; dbl < 2; dbl++)
          for (int bur = 0; bur < 2; bur++)
            run_xfer(sz, src[0], dbl[0], bur[0], 16'h1000 + 16'(sz * 64), 3 * ((sz == 0) ? 1 : (sz == 1) ? 2 : 4));
    run_xfer(1, 1'b0, 1'b0, 1'b1, 16'h2001, 5);

    // R9: requests ignored after completion
    req_n = 1'b0;
    watch(8, r);
    chk(r == 0 && !busy, "R9 ignored after done", r, 0);
    req_n = 1'b1;
    do_start(0, 1'b0, 1'b0, 1'b1, 16'h0100, 16'd0);
    chk(!busy, "R9 zero count idle", int'(busy), 0);

    // R4 / R5 latency
    for (int dbl = 0; dbl < 2; dbl++) begin
      do_start(0, 1'b0, dbl[0], 1'b1, 16'h0100, 16'd4);
      repeat (3) @(negedge clk);
      req_n = 1'b0;
      n = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        n++;
        if (addr_strobe) break;
      end
      req_n = 1'b1;
      if (dbl == 0) chk(n == 3, "R4 single-sample latency", n, 3);
      else chk(n == 4, "R5 double-sample latency", n, 4);
    end

    // R5 one-sample pulse rejected, R4 accepted
    for (int dbl = 1; dbl >= 0; dbl--) begin
      do_start(0, 1'b0, dbl[0], 1'b1, 16'h0200, 16'd4);
      repeat (2) @(negedge clk);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      watch(8, r);
      if (dbl == 1) chk(r == 0, "R5 short request ignored", r, 0);
      else chk(r == 1, "R4 short request accepted", r, 1);
    end

    // R6 held request gives one transfer
    do_start(0, 1'b1, 1'b0, 1'b0, 16'h0300, 16'd8);
    req_n = 1'b0;
    watch(20, r);
    chk(r == 1 && busy, "R6 held request single transfer", r, 1);
    req_n = 1'b1;
    repeat (2) @(negedge clk);
    req_n = 1'b0;
    watch(10, r);
    chk(r == 1, "R6 re-request after release", r, 1);
    req_n = 1'b1;

    // R7 burst stops after request raised
    do_start(0, 1'b0, 1'b0, 1'b1, 16'h0400, 16'd20);
    req_n = 1'b0;
    begin
      logic prev = 1'b0;
      r = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (addr_strobe && !prev) begin
          r++;
          if (r == 2) req_n = 1'b1;
        end
        prev = addr_strobe;
      end
    end
    chk(r == 2 && busy, "R7 burst stop", r, 2);

    // R10 grant wait
    bus_grant = 1'b0;
    do_start(0, 1'b0, 1'b0, 1'b1, 16'h0500, 16'd4);
    req_n = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (addr_strobe || ack) n++;
    end
    chk(n == 0 && busy, "R10 no cycle without grant", n, 0);
    bus_grant = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n++;
      if (addr_strobe) break;
    end
    chk(n == 2, "R10 strobe after grant", n, 2);
    req_n = 1'b1;

    // R11 window refusal
    do_start(0, 1'b0, 1'b0, 1'b1, 16'hF004, 16'd4);
    req_n = 1'b0;
    watch(6, r);
    chk(r == 0 && err && !busy, "R11 window refused", r, 0);
    req_n = 1'b1;
    do_start(0, 1'b0, 1'b0, 1'b1, 16'h0600, 16'd4);
    chk(!err && busy, "R11 start clears err", int'(err), 0);
    do_start(1, 1'b0, 1'b0, 1'b1, 16'hEFFE, 16'd8);
    req_n = 1'b0;
    watch(15, r);
    chk(r == 1 && err && !busy, "R11 burst into window", r, 1);
    req_n = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule